// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps track of the packets held in a receive buffer and shows a 16-bit status word for the packet at the head of the queue. The receive MAC marks the start of a packet, strobes once for each byte it stores, and marks the end of the packet with an error class. Each finished packet becomes a queue entry. The entry holds the byte count and an error code, and the length check can change that code. The host reads the head word, consumes bytes through a read strobe, and retires the head packet with a discard command.

At most `DEPTH` packets can be in the queue. This count includes the packet that is still arriving. While the queue is full, a status-overrun flag is raised and new packets are turned away. The flag drops by itself once a packet has been discarded. If the host reads past the bytes the head packet holds, a sticky underrun failure is raised. Only a receive reset or a block reset clears it.

Top module: `rxq_status_queue`

## Requirements
- R1: After reset, and whenever no packet is queued or arriving, `head_status` is 16'h8000. After reset, `status_overrun`, `rx_underrun` and `rx_complete` are all 0.
- R2: When the head packet is still arriving, `head_status` has bit 15 set, bits 14:11 at 0, and bits 10:0 equal to the number of `pkt_byte` strobes seen since its start. A strobe in the same cycle as `pkt_end` is counted.
- R3: The cycle after `pkt_end`, a completed head shows bit 15 at 0, bits 10:0 at the byte count, and bits 14:11 set by `pkt_err`: 0 none→0000, 1 overrun→1000, 2 runt→1011, 3 alignment→1100, 4 CRC→1101, 5 dribble→0010. The values 6 and 7 are treated as none.
- R4: The byte count stops at 1514. A packet that gets more than 1514 byte strobes completes with code 1001 (oversize), whatever its `pkt_err` is. A packet of exactly 1514 bytes keeps its `pkt_err` code.
- R5: When completed packets plus the arriving packet number `DEPTH` (8), `status_overrun` is 1. A `pkt_start` in that state is refused, and its bytes and end have no effect on the queue.
- R6: `status_overrun` returns to 0 in the cycle after a `discard` removes a packet from a full queue, with no other host action.
- R7: `discard` pops the completed head packet, and the next packet's word shows in the following cycle, in arrival order. A `discard` with no completed packet is ignored, and an arriving packet is not affected by it.
- R8: `rx_complete` is high for exactly one cycle each time a completed packet becomes the head. This happens after the end of the head packet, or after a `discard` exposes a packet that has already completed.
- R9: A `host_rd` strobe when the bytes already read from the head equal its count sets `rx_underrun`. The flag stays set through discards until a reset.
- R10: `rx_reset` empties the queue, drops the arriving packet and clears `status_overrun`, `rx_underrun` and the read count. In the next cycle `head_status` is 16'h8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_reset | input | 1 | Receive reset command |
| pkt_start | input | 1 | MAC begins storing a packet |
| pkt_byte | input | 1 | MAC stored one byte of the arriving packet |
| pkt_end | input | 1 | MAC finished the arriving packet |
| pkt_err | input | 3 | Error class reported with `pkt_end` |
| host_rd | input | 1 | Host consumed one byte of the head packet |
| discard | input | 1 | Discard-top-packet command |
| head_status | output | 16 | Status word of the head packet |
| rx_complete | output | 1 | One-cycle event: completed packet at head |
| status_overrun | output | 1 | Queue full, new packets refused |
| rx_underrun | output | 1 | Sticky read-past-end failure |

## Verification
The hardest state to reach is a full queue in which the last slot is taken by a packet that is still arriving. The same goes for showing that a packet refused during overrun leaves no trace. The stimulus first fills seven slots with completed packets and starts an eighth, then checks the flag. It then sends a complete packet while the queue is full and drains the queue. The scoreboard pairs each completion event with the expected word, so an extra or missing entry shows up as a mismatch or as a leftover item. A second run of 1520 byte strobes drives the length past the cap, and it is checked against the exact-cap length.

// File: rtl/rxq_pkg.sv
// Shared types and status-word encoding for the receive status queue.
// Assumes a 16-bit status word with an 11-bit length field.
package rxq_pkg;
    localparam int STAT_W = 16;
    localparam int LEN_W  = 11;

    typedef enum logic [2:0] {
        MAC_OK      = 3'd0,
        MAC_OVERRUN = 3'd1,
        MAC_RUNT    = 3'd2,
        MAC_ALIGN   = 3'd3,
        MAC_CRC     = 3'd4,
        MAC_DRIBBLE = 3'd5
    } mac_err_e;

    localparam logic [3:0] CODE_NONE     = 4'b0000;
    localparam logic [3:0] CODE_OVERRUN  = 4'b1000;
    localparam logic [3:0] CODE_RUNT     = 4'b1011;
    localparam logic [3:0] CODE_ALIGN    = 4'b1100;
    localparam logic [3:0] CODE_CRC      = 4'b1101;
    localparam logic [3:0] CODE_OVERSIZE = 4'b1001;
    localparam logic [3:0] CODE_DRIBBLE  = 4'b0010;

    // Map a MAC error class to the 4-bit status code; length overflow wins.
    function automatic logic [3:0] err_code(input logic [2:0] cls, input logic oversize);
        logic [3:0] c;
        if (oversize) begin
            c = CODE_OVERSIZE;
        end else begin
            case (cls)
                MAC_OVERRUN: c = CODE_OVERRUN;
                MAC_RUNT:    c = CODE_RUNT;
                MAC_ALIGN:   c = CODE_ALIGN;
                MAC_CRC:     c = CODE_CRC;
                MAC_DRIBBLE: c = CODE_DRIBBLE;
                default:     c = CODE_NONE;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/rxq_arrival.sv
// Tracks the single packet the MAC is currently storing: running length,
// saturation at MAX_BYTES, and the finished status word on its end.
// Assumes start_ok is only raised while not busy.
module rxq_arrival
    import rxq_pkg::*;
#(
    parameter int MAX_BYTES = 1514
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start_ok,
    input  logic              byte_in,
    input  logic              end_in,
    input  logic [2:0]        err_in,
    output logic              busy,
    output logic [LEN_W-1:0]  run_len,
    output logic              push,
    output logic [STAT_W-1:0] push_word
);
    logic             over;
    logic [LEN_W-1:0] len_nx;
    logic             over_nx;

    // Next length and overflow, counting a byte in the current cycle.
    always_comb begin
        len_nx  = run_len;
        over_nx = over;
        if (busy && byte_in) begin
            if (run_len == LEN_W'(MAX_BYTES)) over_nx = 1'b1;
            else                              len_nx  = run_len + 1'b1;
        end
    end

    assign push      = busy && end_in;
    assign push_word = {1'b0, err_code(err_in, over_nx), len_nx};

    // Packet-in-progress state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy    <= 1'b0;
            run_len <= '0;
            over    <= 1'b0;
        end else if (start_ok) begin
            busy    <= 1'b1;
            run_len <= '0;
            over    <= 1'b0;
        end else if (busy) begin
            busy    <= !end_in;
            run_len <= len_nx;
            over    <= over_nx;
        end
    end

    a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len <= LEN_W'(MAX_BYTES));
endmodule

// File: rtl/rxq_store.sv
// Circular store of completed packet status words, oldest at the head.
// Assumes push never arrives when full and pop only when non-empty.
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [STAT_W-1:0] push_word,
    input  logic              pop,
    output logic [STAT_W-1:0] head_word,
    output logic [OCC_W-1:0]  fill
);
    logic [STAT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_word = slots[rd_ptr];

    // Slot write on push.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_word;
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> fill < OCC_W'(DEPTH));
    a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> fill != '0);
endmodule

// File: rtl/rxq_rd_guard.sv
// Counts host reads from the head packet and raises a sticky underrun
// when a read goes past the head's length. Cleared only by reset.
module rxq_rd_guard
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             host_rd,
    input  logic             pop,
    input  logic [LEN_W-1:0] head_len,
    output logic             underrun
);
    logic [LEN_W-1:0] rd_cnt;

    // Read counter per head packet and sticky failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_cnt   <= '0;
            underrun <= 1'b0;
        end else if (pop) begin
            rd_cnt <= '0;
        end else if (host_rd) begin
            if (rd_cnt >= head_len) underrun <= 1'b1;
            else                    rd_cnt   <= rd_cnt + 1'b1;
        end
    end

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !clr |=> underrun);
endmodule

// File: rtl/rxq_status_queue.sv
// Receive packet status queue: combines the arrival tracker, the completed
// entry store and the read guard; produces the head word, the completion
// event and the overrun flag. Assumes MAC strobes are single-cycle.
module rxq_status_queue
    import rxq_pkg::*;
#(
    parameter  int DEPTH     = 8,
    parameter  int MAX_BYTES = 1514,
    localparam int OCC_W     = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_reset,
    input  logic        pkt_start,
    input  logic        pkt_byte,
    input  logic        pkt_end,
    input  logic [2:0]  pkt_err,
    input  logic        host_rd,
    input  logic        discard,
    output logic [15:0] head_status,
    output logic        rx_complete,
    output logic        status_overrun,
    output logic        rx_underrun
);
    logic              arr_busy;
    logic [LEN_W-1:0]  arr_len;
    logic              push;
    logic [STAT_W-1:0] push_word;
    logic [STAT_W-1:0] head_word;
    logic [OCC_W-1:0]  fill;
    logic              pop;
    logic              start_ok;
    logic              head_ready;
    logic              seen;

    // Occupancy counts the arriving packet as well.
    assign status_overrun = (fill + OCC_W'(arr_busy)) == OCC_W'(DEPTH);
    assign start_ok       = pkt_start && !arr_busy && !status_overrun;
    assign pop            = discard && (fill != '0);
    assign head_ready     = fill != '0;

    rxq_arrival #(.MAX_BYTES(MAX_BYTES)) u_arrival (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset), .start_ok(start_ok),
        .byte_in(pkt_byte), .end_in(pkt_end), .err_in(pkt_err),
        .busy(arr_busy), .run_len(arr_len), .push(push), .push_word(push_word)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset), .push(push),
        .push_word(push_word), .pop(pop), .head_word(head_word), .fill(fill)
    );

    // Head word: completed entry, else arriving packet, else empty marker.
    always_comb begin
        if (head_ready)    head_status = head_word;
        else if (arr_busy) head_status = {1'b1, 4'b0000, arr_len};
        else               head_status = 16'h8000;
    end

    rxq_rd_guard u_rd_guard (
        .clk(clk), .rst_n(rst_n), .clr(rx_reset), .host_rd(host_rd),
        .pop(pop), .head_len(head_status[LEN_W-1:0]), .underrun(rx_underrun)
    );

    // Remembers that the current completed head has already been announced.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset || pop) seen <= 1'b0;
        else                           seen <= head_ready;
    end

    assign rx_complete = head_ready && !seen;

    a_r5_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        status_overrun && pkt_start && !arr_busy |=> !arr_busy);
    a_r6_overrun_release: assert property (@(posedge clk) disable iff (!rst_n)
        status_overrun && discard && !rx_reset |=> !status_overrun);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete && !discard |=> !rx_complete);
    a_r10_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> head_status == 16'h8000 && !status_overrun && !rx_underrun);
endmodule

// File: tb/test_rxq_status_queue.sv
module test_rxq_status_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_reset = 1'b0;
    logic        pkt_start = 1'b0;
    logic        pkt_byte = 1'b0;
    logic        pkt_end = 1'b0;
    logic [2:0]  pkt_err = 3'd0;
    logic        host_rd = 1'b0;
    logic        discard = 1'b0;
    logic [15:0] head_status;
    logic        rx_complete;
    logic        status_overrun;
    logic        rx_underrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    rxq_status_queue i_rxq_status_queue (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .pkt_start(pkt_start),
        .pkt_byte(pkt_byte), .pkt_end(pkt_end), .pkt_err(pkt_err),
        .host_rd(host_rd), .discard(discard), .head_status(head_status),
        .rx_complete(rx_complete), .status_overrun(status_overrun),
        .rx_underrun(rx_underrun)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] exp_word(input int n, input logic [2:0] err);
        logic [3:0] c;
        int len;
        case (err)
            3'd1: c = 4'b1000;
            3'd2: c = 4'b1011;
            3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;
            3'd5: c = 4'b0010;
            default: c = 4'b0000;
        endcase
        len = n;
        if (n > 1514) begin
            c = 4'b1001;
            len = 1514;
        end
        return {1'b0, c, 11'(len)};
    endfunction

    task automatic begin_pkt(input int n);
        pkt_start = 1'b1; step(); pkt_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pkt_byte = 1'b1; step();
        end
        pkt_byte = 1'b0;
    endtask

    task automatic finish_pkt(input int n, input logic [2:0] err, input bit accepted);
        if (accepted) exp_q.push_back(exp_word(n, err));
        pkt_err = err; pkt_end = 1'b1; step(); pkt_end = 1'b0; pkt_err = 3'd0;
    endtask

    task automatic send_pkt(input int n, input logic [2:0] err, input bit accepted);
        begin_pkt(n);
        finish_pkt(n, err, accepted);
    endtask

    task automatic do_discard();
        discard = 1'b1; step(); discard = 1'b0;
    endtask

    // Scoreboard monitor: each completion event must match the next expected word (R3, R8).
    always @(negedge clk) begin
        if (rst_n && !rx_reset && rx_complete) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected completion actual=%h expected=none", head_status);
            end else begin
                chk("R3 scoreboard head word", head_status, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 empty word", head_status, 16'h8000);
        chk("R1 flags", {13'd0, status_overrun, rx_underrun, rx_complete}, 16'h0000);

        // R2 running count
        begin_pkt(5);
        chk("R2 running count", head_status, 16'h8005);
        // R3/R8 completion with CRC class
        finish_pkt(5, 3'd4, 1'b1);
        chk("R3 crc word", head_status, 16'h6805);
        chk("R8 pulse high", {15'd0, rx_complete}, 16'd1);
        step();
        chk("R8 pulse one cycle", {15'd0, rx_complete}, 16'd0);
        do_discard();
        chk("R7 empty after discard", head_status, 16'h8000);

        // R3/R7 several classes, FIFO order
        send_pkt(10, 3'd0, 1'b1);
        send_pkt(60, 3'd2, 1'b1);
        send_pkt(3, 3'd5, 1'b1);
        send_pkt(7, 3'd3, 1'b1);
        send_pkt(9, 3'd1, 1'b1);
        chk("R3 head stays first", head_status, exp_word(10, 3'd0));
        do_discard();
        chk("R7 next head", head_status, 16'h583C);
        chk("R8 pulse after discard", {15'd0, rx_complete}, 16'd1);
        repeat (4) do_discard();
        chk("R7 drained", head_status, 16'h8000);

        // R4 length cap
        send_pkt(1514, 3'd0, 1'b1);
        chk("R4 exact cap", head_status, 16'h05EA);
        do_discard();
        send_pkt(1520, 3'd4, 1'b1);
        chk("R4 oversize", head_status, 16'h4DEA);
        do_discard();

        // R7 discard ignored while only an arriving packet exists
        begin_pkt(3);
        do_discard();
        chk("R7 arriving untouched", head_status, 16'h8003);
        finish_pkt(3, 3'd0, 1'b1);
        do_discard();

        // R5 occupancy includes arriving packet
        for (int i = 0; i < 7; i++) send_pkt(i + 1, 3'd0, 1'b1);
        chk("R5 not full at seven", {15'd0, status_overrun}, 16'd0);
        begin_pkt(2);
        chk("R5 full with arriving", {15'd0, status_overrun}, 16'd1);
        finish_pkt(2, 3'd0, 1'b1);
        send_pkt(4, 3'd4, 1'b0);
        chk("R5 refused leaves head", head_status, exp_word(1, 3'd0));
        chk("R5 still full", {15'd0, status_overrun}, 16'd1);
        do_discard();
        chk("R6 overrun released", {15'd0, status_overrun}, 16'd0);
        repeat (7) do_discard();
        chk("R5 refused packet absent", head_status, 16'h8000);
        chk("R5 scoreboard drained", 16'(exp_q.size()), 16'd0);

        // R9 underrun
        send_pkt(4, 3'd0, 1'b1);
        host_rd = 1'b1;
        repeat (4) step();
        host_rd = 1'b0;
        chk("R9 in-range reads", {15'd0, rx_underrun}, 16'd0);
        host_rd = 1'b1; step(); host_rd = 1'b0;
        chk("R9 read past end", {15'd0, rx_underrun}, 16'd1);
        do_discard();
        chk("R9 sticky over discard", {15'd0, rx_underrun}, 16'd1);

        // R10 receive reset
        send_pkt(6, 3'd0, 1'b1);
        send_pkt(8, 3'd0, 1'b1);
        begin_pkt(2);
        rx_reset = 1'b1; step(); rx_reset = 1'b0;
        exp_q.delete();
        chk("R10 empty word", head_status, 16'h8000);
        chk("R10 flags", {14'd0, status_overrun, rx_underrun}, 16'd0);
        send_pkt(2, 3'd0, 1'b1);
        chk("R10 queue usable", head_status, 16'h0002);
        do_discard();

        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule